// File: doc/BRIEF.md
# MSI-X Interrupt Message Generator

This block converts interrupt requests raised by an accelerator into message-signalled interrupt write requests for a PCIe link. A request names a context and a logical source number. The block adds that context's programmable offset to the source number, producing a 16-bit vector index. A separate error-interrupt request skips the offset and limit and uses its own programmed vector index. The index then becomes a 64-bit write address and a 32-bit write data word. The rule for this depends on the active address mode.

There are three address modes:
- **Fixed base:** the index, shifted left by one nibble, is OR-ed into a constant platform address. The data is zero.
- **Single entry:** the same OR-ing is done, but the base comes from entry 0 of a small internal vector table. The data is zero.
- **Full table:** the index selects a table entry, and the entry supplies both address and data. A masked entry records a pending bit instead of writing. Unmasking that entry later releases the write.

One write request is outstanding at a time. It is presented on a valid/ready pair until the transaction layer takes it.

Software reaches the block through a simple register port with a one-cycle write strobe and a combinational read. The register map uses these word addresses:
- `0x00` capability/status: address mode in bits 14:13, sticky range-error flag in bit 0.
- `0x01` error vector index, bits 15:0.
- `0x02` pending bits, one per table entry, read-only.
- `0x10+c` context c: offset in bits 15:0, limit in bits 31:16.
- `0x20+2e` table entry e address, 64 bits.
- `0x21+2e` table entry e: data in bits 31:0, mask in bit 32.

Top module: `msix_irq_gen`

## Requirements
- R1: After reset, the mode is 00, the range-error flag is 0, no pending bit is set, `outValid` is 0, and every table entry is masked (bit 32 reads 1). Register 0x00 reads the mode in bits 14:13 and the flag in bit 0. Mode encodings are: 00 fixed base, 01 single entry, 10 full table, and 11 behaves as fixed base.
- R2: A request's vector index is the context offset plus the source number, modulo 2^16. A source number greater than the context limit produces no write. Instead it sets the sticky range-error flag, which stays set until a register-0x00 write with bit 0 at 1.
- R3: In fixed-base mode, the write address is 64'h1000_0000_0000_0000 OR (index << 4), and the data is 0.
- R4: In single-entry mode, the write address is table entry 0's address OR (index << 4), and the data is 0. Masks and pending bits play no part; a masked entry 0 still writes.
- R5: In full-table mode, the index selects a table entry, whose address and data are written. An index at or beyond the table depth produces no write and sets the range-error flag.
- R6: In full-table mode, a request to a masked entry produces no write. It sets that entry's bit in the pending register (0x02, bit e for entry e).
- R7: In full-table mode, an entry that is unmasked and pending is written and its pending bit cleared. Such releases go ahead of new requests, lowest entry first.
- R8: An error request uses the error vector register (0x01) as its index, without offset or limit. When both request kinds are valid together, the error request is taken first.
- R9: While `outValid` is high and `outReady` low, the address and data hold steady and neither request input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register word address |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data for `regAddr` |
| reqValid | input | 1 | Source-interrupt request valid |
| reqReady | output | 1 | Source-interrupt request accepted this cycle |
| reqCtx | input | CTX_W | Context number of the request |
| reqLisn | input | 16 | Logical source number |
| errValid | input | 1 | Error-interrupt request valid |
| errReady | output | 1 | Error-interrupt request accepted this cycle |
| outValid | output | 1 | Write request valid |
| outReady | input | 1 | Write request taken |
| outAddr | output | 64 | Write address |
| outData | output | 32 | Write data |

## Verification
Several of the block's functions can fall due in the same cycle. The main case is a pending release becoming eligible in the same cycle that new source and error requests are waiting. The bench provokes this in full-table mode:
1. It holds `outReady` low with one write stuck at the output.
2. It unmasks a pending entry.
3. It raises an error request and a source request together.

When `outReady` returns, the scoreboard must see the stuck write first, then the released entry, then the error vector's entry, and then the source request's entry. Any other order is a mismatch.

// File: rtl/msix_pkg.sv
package msix_pkg;

  localparam int IDX_W = 16;

  typedef enum logic [1:0] {
    MODE_FIXED  = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_FULL   = 2'b10,
    MODE_RSVD   = 2'b11
  } msixMode_e;

  typedef struct packed {
    logic loadOut;
    logic setPend;
    logic clrPend;
    logic setRangeErr;
    logic useErr;
    logic useRelease;
  } msixStrobe_t;

  localparam logic [63:0] FIXED_BASE = 64'h1000_0000_0000_0000;

  localparam logic [7:0] REG_CAP      = 8'h00;
  localparam logic [7:0] REG_ERRVEC   = 8'h01;
  localparam logic [7:0] REG_PBA      = 8'h02;
  localparam logic [7:0] REG_CTX_BASE = 8'h10;
  localparam logic [7:0] REG_TBL_BASE = 8'h20;

endpackage

// File: rtl/msix_ctrl.sv
module msix_ctrl
  import msix_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        errValid,
  input  logic        outReady,
  input  logic        isFull,
  input  logic        lisnOver,
  input  logic        lisnBeyond,
  input  logic        lisnMasked,
  input  logic        errBeyond,
  input  logic        errMasked,
  input  logic        relAvail,
  output logic        reqReady,
  output logic        errReady,
  output logic        outValid,
  output msixStrobe_t strobe
);

  logic outFree;

  assign outFree  = !outValid;
  assign errReady = outFree && !relAvail;
  assign reqReady = outFree && !relAvail && !errValid;

  // Priority: pending release, then error request, then source request.
  always_comb begin
    strobe = '0;
    if (outFree && relAvail) begin
      strobe.loadOut    = 1'b1;
      strobe.clrPend    = 1'b1;
      strobe.useRelease = 1'b1;
    end else if (outFree && errValid) begin
      strobe.useErr = 1'b1;
      if (isFull && errBeyond)      strobe.setRangeErr = 1'b1;
      else if (isFull && errMasked) strobe.setPend     = 1'b1;
      else                          strobe.loadOut     = 1'b1;
    end else if (outFree && reqValid) begin
      if (lisnOver)                  strobe.setRangeErr = 1'b1;
      else if (isFull && lisnBeyond) strobe.setRangeErr = 1'b1;
      else if (isFull && lisnMasked) strobe.setPend     = 1'b1;
      else                           strobe.loadOut     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                outValid <= 1'b0;
    else if (strobe.loadOut)  outValid <= 1'b1;
    else if (outReady)        outValid <= 1'b0;
  end

endmodule

// File: rtl/msix_datapath.sv
module msix_datapath
  import msix_pkg::*;
#(
  parameter int NUM_CTX   = 4,
  parameter int TBL_DEPTH = 8,
  parameter int CTX_W     = 2,
  parameter int TIDX_W    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [7:0]         regAddr,
  input  logic [63:0]        regWrData,
  output logic [63:0]        regRdData,
  input  logic [CTX_W-1:0]   reqCtx,
  input  logic [IDX_W-1:0]   reqLisn,
  input  msixStrobe_t        strobe,
  output logic               lisnOver,
  output logic               lisnBeyond,
  output logic               lisnMasked,
  output logic               errBeyond,
  output logic               errMasked,
  output logic               relAvail,
  output logic               isFull,
  output logic [1:0]         mode,
  output logic               rangeErr,
  output logic [63:0]        outAddr,
  output logic [31:0]        outData
);

  localparam logic [IDX_W-1:0] DEPTH_LIM = IDX_W'(TBL_DEPTH);

  logic [IDX_W-1:0]  ctxOffset [NUM_CTX];
  logic [IDX_W-1:0]  ctxLimit  [NUM_CTX];
  logic [IDX_W-1:0]  errVec;
  logic [63:0]       tblAddr   [TBL_DEPTH];
  logic [31:0]       tblData   [TBL_DEPTH];
  logic [TBL_DEPTH-1:0] tblMask;
  logic [TBL_DEPTH-1:0] pend;
  logic [TBL_DEPTH-1:0] relReady;

  logic [IDX_W-1:0]  lisnIdx;
  logic [IDX_W-1:0]  selIdx;
  logic [TIDX_W-1:0] selTidx;
  logic [TIDX_W-1:0] relIdx;
  logic              isSingle;
  logic              capWrite;
  logic [63:0]       nibBase;
  logic [63:0]       nextAddr;
  logic [31:0]       nextData;

  assign isFull   = (mode == MODE_FULL);
  assign isSingle = (mode == MODE_SINGLE);
  assign capWrite = regWrEn && (regAddr == REG_CAP);

  // Source mapping through the context offset/limit pair
  assign lisnIdx    = ctxOffset[reqCtx] + reqLisn;
  assign lisnOver   = reqLisn > ctxLimit[reqCtx];
  assign lisnBeyond = lisnIdx >= DEPTH_LIM;
  assign lisnMasked = tblMask[lisnIdx[TIDX_W-1:0]];
  assign errBeyond  = errVec >= DEPTH_LIM;
  assign errMasked  = tblMask[errVec[TIDX_W-1:0]];

  assign selIdx  = strobe.useErr ? errVec : lisnIdx;
  assign selTidx = selIdx[TIDX_W-1:0];

  // Release selection: lowest unmasked pending entry, full-table mode only
  assign relReady = pend & ~tblMask;
  assign relAvail = isFull && (|relReady);

  always_comb begin
    relIdx = '0;
    for (int i = TBL_DEPTH - 1; i >= 0; i--) begin
      if (relReady[i]) relIdx = TIDX_W'(i);
    end
  end

  // Address and data formation
  assign nibBase = isSingle ? tblAddr[0] : FIXED_BASE;

  always_comb begin
    if (strobe.useRelease) begin
      nextAddr = tblAddr[relIdx];
      nextData = tblData[relIdx];
    end else if (isFull) begin
      nextAddr = tblAddr[selTidx];
      nextData = tblData[selTidx];
    end else begin
      nextAddr = nibBase | {44'b0, selIdx, 4'b0};
      nextData = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAddr <= '0;
      outData <= '0;
    end else if (strobe.loadOut) begin
      outAddr <= nextAddr;
      outData <= nextData;
    end
  end

  // Status and mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_FIXED;
      rangeErr <= 1'b0;
      errVec   <= '0;
    end else begin
      if (capWrite) mode <= regWrData[14:13];
      if (strobe.setRangeErr)           rangeErr <= 1'b1;
      else if (capWrite && regWrData[0]) rangeErr <= 1'b0;
      if (regWrEn && regAddr == REG_ERRVEC) errVec <= regWrData[IDX_W-1:0];
    end
  end

  // Context registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        ctxOffset[c] <= '0;
        ctxLimit[c]  <= '0;
      end
    end else if (regWrEn) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (regAddr == REG_CTX_BASE + 8'(c)) begin
          ctxOffset[c] <= regWrData[15:0];
          ctxLimit[c]  <= regWrData[31:16];
        end
      end
    end
  end

  // Vector table and pending bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < TBL_DEPTH; e++) begin
        tblAddr[e] <= '0;
        tblData[e] <= '0;
      end
      tblMask <= '1;
      pend    <= '0;
    end else begin
      if (regWrEn) begin
        for (int e = 0; e < TBL_DEPTH; e++) begin
          if (regAddr == REG_TBL_BASE + 8'(2 * e)) tblAddr[e] <= regWrData;
          if (regAddr == REG_TBL_BASE + 8'(2 * e + 1)) begin
            tblData[e] <= regWrData[31:0];
            tblMask[e] <= regWrData[32];
          end
        end
      end
      if (strobe.setPend) pend[selTidx] <= 1'b1;
      if (strobe.clrPend) pend[relIdx]  <= 1'b0;
    end
  end

  // Register read
  always_comb begin
    regRdData = '0;
    if (regAddr == REG_CAP)    regRdData = {49'b0, mode, 12'b0, rangeErr};
    if (regAddr == REG_ERRVEC) regRdData = {48'b0, errVec};
    if (regAddr == REG_PBA)    regRdData = 64'(pend);
    for (int c = 0; c < NUM_CTX; c++) begin
      if (regAddr == REG_CTX_BASE + 8'(c))
        regRdData = {32'b0, ctxLimit[c], ctxOffset[c]};
    end
    for (int e = 0; e < TBL_DEPTH; e++) begin
      if (regAddr == REG_TBL_BASE + 8'(2 * e))     regRdData = tblAddr[e];
      if (regAddr == REG_TBL_BASE + 8'(2 * e + 1)) regRdData = {31'b0, tblMask[e], tblData[e]};
    end
  end

endmodule

// File: rtl/msix_irq_gen.sv
module msix_irq_gen
  import msix_pkg::*;
#(
  parameter int  NUM_CTX   = 4,
  parameter int  TBL_DEPTH = 8,
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int TIDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [7:0]       regAddr,
  input  logic [63:0]      regWrData,
  output logic [63:0]      regRdData,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [CTX_W-1:0] reqCtx,
  input  logic [15:0]      reqLisn,
  input  logic             errValid,
  output logic             errReady,
  output logic             outValid,
  input  logic             outReady,
  output logic [63:0]      outAddr,
  output logic [31:0]      outData
);

  msixStrobe_t strobe;
  logic        lisnOver, lisnBeyond, lisnMasked;
  logic        errBeyond, errMasked;
  logic        relAvail, isFull, rangeErr;
  logic [1:0]  mode;

  msix_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .errValid   (errValid),
    .outReady   (outReady),
    .isFull     (isFull),
    .lisnOver   (lisnOver),
    .lisnBeyond (lisnBeyond),
    .lisnMasked (lisnMasked),
    .errBeyond  (errBeyond),
    .errMasked  (errMasked),
    .relAvail   (relAvail),
    .reqReady   (reqReady),
    .errReady   (errReady),
    .outValid   (outValid),
    .strobe     (strobe)
  );

  msix_datapath #(
    .NUM_CTX   (NUM_CTX),
    .TBL_DEPTH (TBL_DEPTH),
    .CTX_W     (CTX_W),
    .TIDX_W    (TIDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .reqCtx     (reqCtx),
    .reqLisn    (reqLisn),
    .strobe     (strobe),
    .lisnOver   (lisnOver),
    .lisnBeyond (lisnBeyond),
    .lisnMasked (lisnMasked),
    .errBeyond  (errBeyond),
    .errMasked  (errMasked),
    .relAvail   (relAvail),
    .isFull     (isFull),
    .mode       (mode),
    .rangeErr   (rangeErr),
    .outAddr    (outAddr),
    .outData    (outData)
  );

endmodule

// File: rtl/msix_irq_gen_chk.sv
module msix_irq_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [7:0]  regAddr,
  input logic        clrBit,
  input logic        reqValid,
  input logic        reqReady,
  input logic        errValid,
  input logic        errReady,
  input logic        outValid,
  input logic        outReady,
  input logic [63:0] outAddr,
  input logic [31:0] outData,
  input logic [1:0]  mode,
  input logic        relAvail,
  input logic        rangeErr
);

  logic flagClear;
  assign flagClear = regWrEn && (regAddr == 8'h00) && clrBit;

  // R9: a stalled write keeps its contents
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outData));

  // R9: no request is taken while a write is outstanding
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !reqReady && !errReady);

  // R8: error request is served ahead of a source request
  a_r8_err_first: assert property (@(posedge clk) disable iff (!rstN)
    errValid && reqValid |-> !reqReady);

  // R7: pending releases come before any new request
  a_r7_release_first: assert property (@(posedge clk) disable iff (!rstN)
    relAvail |-> !reqReady && !errReady);

  // R3: fixed-base writes carry the constant base and a clear low nibble
  a_r3_fixed_form: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) && $past(mode) == 2'b00 |->
      outAddr[63:20] == 44'h10000000000 && outAddr[3:0] == 4'h0);

  // R4: outside full-table mode the data word is zero
  a_r4_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) && $past(mode) != 2'b10 |-> outData == 32'h0);

  // R2: the range-error flag is sticky until cleared by software
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr && !flagClear |=> rangeErr);

endmodule

bind msix_irq_gen msix_irq_gen_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .clrBit   (regWrData[0]),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .errValid (errValid),
  .errReady (errReady),
  .outValid (outValid),
  .outReady (outReady),
  .outAddr  (outAddr),
  .outData  (outData),
  .mode     (mode),
  .relAvail (relAvail),
  .rangeErr (rangeErr)
);

// File: tb/msix_irq_gen_test.sv
`timescale 1ns/1ps
module msix_irq_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqCtx = '0;
  logic [15:0] reqLisn = '0;
  logic        errValid = 1'b0;
  logic        errReady;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] outAddr;
  logic [31:0] outData;

  int compared = 0;
  int mismatched = 0;

  logic [95:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  msix_irq_gen uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqReady(reqReady), .reqCtx(reqCtx), .reqLisn(reqLisn),
    .errValid(errValid), .errReady(errReady), .outValid(outValid),
    .outReady(outReady), .outAddr(outAddr), .outData(outData)
  );

  function automatic logic [63:0] fixedAddr(input logic [15:0] idx);
    return 64'h1000_0000_0000_0000 | {44'b0, idx, 4'b0};
  endfunction

  function automatic logic [63:0] entAddr(input int e);
    return 64'h0000_00FE_E000_0000 | (64'(e) << 8);
  endfunction

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectWrite(input string tag, input logic [63:0] a, input logic [31:0] d);
    expQ.push_back({a, d});
    tagQ.push_back(tag);
  endtask

  // Monitor: compare every accepted write against the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL unexpected write actual=%h expected=none", {outAddr, outData});
      end else begin
        logic [95:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {outAddr, outData}, e);
      end
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sendLisn(input logic [1:0] c, input logic [15:0] l);
    @(negedge clk);
    reqValid = 1'b1; reqCtx = c; reqLisn = l;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic sendErr();
    @(negedge clk);
    errValid = 1'b1;
    #1;
    while (!errReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    errValid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (expQ.size() != 0 && n < 200) begin @(posedge clk); n++; end
    repeat (3) @(posedge clk);
    check("scoreboard empty", 96'(expQ.size()), 96'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 outValid after reset", 96'(outValid), 96'd0);
    check("R1 reqReady after reset", 96'(reqReady), 96'd1);
    regRead(8'h00, rd); check("R1 cap after reset", 96'(rd), 96'h0);
    regRead(8'h02, rd); check("R1 pending after reset", 96'(rd), 96'h0);
    regRead(8'h21, rd); check("R1 entry0 masked", 96'(rd[32]), 96'd1);

    // contexts and error vector
    regWrite(8'h10, {32'b0, 16'h000F, 16'h0100});
    regWrite(8'h11, {32'b0, 16'h0020, 16'hFFF0});
    regWrite(8'h12, {32'b0, 16'h0007, 16'h0000});
    regWrite(8'h01, 64'h0ABC);

    // R3 fixed base mode, R2 mapping
    expectWrite("R3 fixed ctx0 lisn5", fixedAddr(16'h0105), 32'h0);
    sendLisn(2'd0, 16'd5);
    expectWrite("R2 wrap ctx1 lisn18", fixedAddr(16'h0002), 32'h0);
    sendLisn(2'd1, 16'h0012);
    expectWrite("R2 lisn equal limit", fixedAddr(16'h010F), 32'h0);
    sendLisn(2'd0, 16'h000F);
    drain();

    // R2 out of range
    sendLisn(2'd0, 16'h0010);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 no write over limit", 96'(outValid), 96'd0);
    regRead(8'h00, rd); check("R2 range flag set", 96'(rd), 96'h1);
    regWrite(8'h00, 64'h1);
    regRead(8'h00, rd); check("R2 range flag cleared", 96'(rd), 96'h0);

    // R8 error vector in fixed mode
    expectWrite("R8 error fixed", fixedAddr(16'h0ABC), 32'h0);
    sendErr();
    drain();

    // R4 single entry mode, entry0 still masked
    regWrite(8'h20, 64'h0000_00FE_E000_0000);
    regWrite(8'h00, 64'h2000);
    regRead(8'h00, rd); check("R1 cap single mode", 96'(rd), 96'h2000);
    expectWrite("R4 single ctx0 lisn3", 64'h0000_00FE_E000_1030, 32'h0);
    sendLisn(2'd0, 16'd3);
    drain();
    regRead(8'h02, rd); check("R4 no pending in single", 96'(rd), 96'h0);

    // R5 full table mode
    for (int e = 0; e < 8; e++) begin
      regWrite(8'(8'h20 + 2 * e), entAddr(e));
      regWrite(8'(8'h21 + 2 * e), {31'b0, (e == 3), 32'h4000 + 32'(e)});
    end
    regWrite(8'h01, 64'h6);
    regWrite(8'h00, 64'h4000);
    regRead(8'h00, rd); check("R1 cap full mode", 96'(rd), 96'h4000);
    expectWrite("R5 full entry1", entAddr(1), 32'h4001);
    sendLisn(2'd2, 16'd1);
    drain();

    // R6 masked entry goes pending
    sendLisn(2'd2, 16'd3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 no write when masked", 96'(outValid), 96'd0);
    regRead(8'h02, rd); check("R6 pending bit 3", 96'(rd), 96'h8);

    // R5 beyond table depth
    sendLisn(2'd0, 16'd2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 no write beyond depth", 96'(outValid), 96'd0);
    regRead(8'h00, rd); check("R5 range flag", 96'(rd), 96'h4001);
    regWrite(8'h00, 64'h4001);

    // R7/R8/R9 collision: stuck write, unmask, error and source together
    @(posedge clk); #1 outReady = 1'b0;
    expectWrite("R9 stalled entry1", entAddr(1), 32'h4001);
    expectWrite("R7 released entry3", entAddr(3), 32'h4003);
    expectWrite("R8 error entry6", entAddr(6), 32'h4006);
    expectWrite("R8 source entry5 after error", entAddr(5), 32'h4005);
    sendLisn(2'd2, 16'd1);
    regWrite(8'h27, {31'b0, 1'b0, 32'h4003});
    fork
      sendErr();
      sendLisn(2'd2, 16'd5);
    join_none
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    check("R9 held while stalled", {outValid, reqReady, errReady, 29'b0, outAddr}, {3'b100, 29'b0, entAddr(1)});
    @(posedge clk); #1 outReady = 1'b1;
    wait fork;
    drain();
    regRead(8'h02, rd); check("R7 pending cleared", 96'(rd), 96'h0);

    // R1 reserved mode behaves as fixed base
    regWrite(8'h00, 64'h6000);
    expectWrite("R1 reserved mode as fixed", fixedAddr(16'h0000), 32'h0);
    sendLisn(2'd2, 16'd0);
    drain();

    summary();
    $finish;
  end

endmodule